// File: doc/BRIEF.md
# Lockable Protected Memory Region Checker

This block sits between memory requesters and memory and enforces access rules on a small set of physical address regions. Region 0 belongs to the kernel. Regions 1 to `NUM_COPROC` belong to the coprocessors, one region each. During boot, software programs a base and a limit for every region through a configuration port. Boot code may write anything while it loads its images. At the end of boot a single pulse on `lock_set` sets a sticky lock. From then on the region registers are frozen and the protection rules apply.

The block checks two kinds of request.

- **Memory writes** carry an address and a requester ID. Once the lock is set, a write into any protected region is denied.
- **Mapping requests** carry a physical page address, a requester ID and three flags: writable, executable and privileged. The rules work in opposite directions inside and outside the requester's own region. An executable or privileged mapping must land inside the requester's own region. A writable mapping must land outside it.

Each decision is registered. A denial pulses `fault` and records the first offending request in a capture register, which holds it until `flt_clear` is asserted.

Top module: `prot_region_guard`

## Requirements
- R1: While `locked` is 0, every write request and every mapping request is answered with allow, whatever its address, ID or flags.
- R2: While `locked` is 1, a write whose address lies in any non-empty region is denied, whatever the requester ID. A write outside all regions is allowed.
- R3: While `locked` is 1, a mapping with `map_x` or `map_p` set is denied unless its address lies in the requester's own region.
- R4: While `locked` is 1, a mapping with `map_w` set is denied when its address lies in the requester's own region. A mapping with no flags set is always allowed.
- R5: Requester ID k, for k from 0 to `NUM_COPROC`, owns only region k, where 0 is the kernel. A coprocessor is never checked against the kernel region or against another coprocessor's region. An ID above `NUM_COPROC` owns no region.
- R6: A region holds the addresses a with base <= a < limit. A region whose limit is less than or equal to its base is empty and matches no address.
- R7: `lock_set` sets `locked` on the next clock edge. `locked` then stays 1 until reset.
- R8: A configuration write is applied only while `locked` is 0. The target is region `cfg_idx`, with `cfg_sel_limit` = 0 selecting the base and 1 selecting the limit. A configuration write while `locked` is 1 changes nothing and pulses `cfg_violation` high for exactly one cycle, in the cycle after the attempt.
- R9: Both request ports are always ready. The response (`*_resp_valid` and `*_allow`) appears exactly one cycle after the request. `fault` is high in that same cycle if and only if a request was denied.
- R10: When `flt_valid` is 0, a denial loads the capture register with address, ID and source (`flt_src` 0 for write, 1 for mapping). When both ports are denied in the same cycle, the write is captured. While `flt_valid` is 1, the capture register keeps its contents until `flt_clear` is asserted, which clears it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region index (0 kernel, k coprocessor k) |
| cfg_sel_limit | input | 1 | 0 writes base, 1 writes limit |
| cfg_wdata | input | ADDR_W | Configuration data |
| lock_set | input | 1 | Sets the sticky lock |
| locked | output | 1 | Lock state |
| cfg_violation | output | 1 | One-cycle pulse on a configuration write while locked |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always 1) |
| wr_addr | input | ADDR_W | Write address |
| wr_id | input | ID_W | Write requester ID |
| wr_resp_valid | output | 1 | Write decision valid |
| wr_allow | output | 1 | Write allowed |
| map_valid | input | 1 | Mapping request valid |
| map_ready | output | 1 | Mapping request ready (always 1) |
| map_addr | input | ADDR_W | Physical page address |
| map_id | input | ID_W | Mapping requester ID |
| map_w | input | 1 | Writable mapping requested |
| map_x | input | 1 | Executable mapping requested |
| map_p | input | 1 | Privileged mapping requested |
| map_resp_valid | output | 1 | Mapping decision valid |
| map_allow | output | 1 | Mapping allowed |
| fault | output | 1 | One-cycle pulse on any denial |
| flt_clear | input | 1 | Clears the capture register |
| flt_valid | output | 1 | Capture register holds a fault |
| flt_src | output | 1 | Source of captured fault (0 write, 1 mapping) |
| flt_addr | output | ADDR_W | Captured address |
| flt_id | output | ID_W | Captured requester ID |

## Verification
The locked phase is checked against a table of writes and mappings. The table is arranged so that each rule can be told apart from its mirror image:

- Executable and writable mappings are aimed at the same kernel page from the kernel ID, from a coprocessor ID, and from an ID that owns no region. This separates the own-region selection from a check against any region.
- Addresses one below the base, at the base, one below the limit and at the limit separate a half-open range from a closed one.
- An empty region configured with its limit below its base must match nothing.

Directed tests then cover the following:

- Writes and writable mappings before the lock are allowed.
- A locked attempt to shrink the kernel region must leave writes into it still denied.
- Simultaneous denials on both ports fix the capture priority.

// File: rtl/prot_region_guard.sv
module prot_region_guard #(
  parameter int ADDR_W     = 32,
  parameter int NUM_COPROC = 2,
  parameter int ID_W       = 2,
  localparam int NREG      = NUM_COPROC + 1,
  localparam int IDX_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel_limit,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              lock_set,
  output logic              locked,
  output logic              cfg_violation,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   wr_id,
  output logic              wr_resp_valid,
  output logic              wr_allow,
  input  logic              map_valid,
  output logic              map_ready,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [ID_W-1:0]   map_id,
  input  logic              map_w,
  input  logic              map_x,
  input  logic              map_p,
  output logic              map_resp_valid,
  output logic              map_allow,
  output logic              fault,
  input  logic              flt_clear,
  output logic              flt_valid,
  output logic              flt_src,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [ID_W-1:0]   flt_id
);

  logic [ADDR_W-1:0] base_q  [NREG];
  logic [ADDR_W-1:0] limit_q [NREG];
  logic [NREG-1:0]   wr_hit, map_hit;
  logic              own_hit, wr_deny, map_deny, wr_bad, map_bad;

  assign wr_ready  = 1'b1;
  assign map_ready = 1'b1;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic nonempty;
    assign nonempty   = limit_q[g] > base_q[g];
    assign wr_hit[g]  = nonempty && (wr_addr  >= base_q[g]) && (wr_addr  < limit_q[g]);
    assign map_hit[g] = nonempty && (map_addr >= base_q[g]) && (map_addr < limit_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (cfg_we && !locked && cfg_idx == IDX_W'(g)) begin
        if (cfg_sel_limit) limit_q[g] <= cfg_wdata;
        else               base_q[g]  <= cfg_wdata;
      end
    end
  end

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (map_id == ID_W'(i)) own_hit = map_hit[i];
  end

  assign wr_deny  = locked && (|wr_hit);
  assign map_deny = locked && (((map_x || map_p) && !own_hit) || (map_w && own_hit));
  assign wr_bad   = wr_valid && wr_deny;
  assign map_bad  = map_valid && map_deny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked         <= 1'b0;
      cfg_violation  <= 1'b0;
      wr_resp_valid  <= 1'b0;
      wr_allow       <= 1'b0;
      map_resp_valid <= 1'b0;
      map_allow      <= 1'b0;
      fault          <= 1'b0;
      flt_valid      <= 1'b0;
      flt_src        <= 1'b0;
      flt_addr       <= '0;
      flt_id         <= '0;
    end else begin
      locked         <= locked | lock_set;
      cfg_violation  <= cfg_we && locked;
      wr_resp_valid  <= wr_valid;
      wr_allow       <= wr_valid && !wr_deny;
      map_resp_valid <= map_valid;
      map_allow      <= map_valid && !map_deny;
      fault          <= wr_bad || map_bad;
      if ((wr_bad || map_bad) && (!flt_valid || flt_clear)) begin
        flt_valid <= 1'b1;
        flt_src   <= !wr_bad;
        flt_addr  <= wr_bad ? wr_addr : map_addr;
        flt_id    <= wr_bad ? wr_id   : map_id;
      end else if (flt_clear) begin
        flt_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prot_region_guard_chk.sv
module prot_region_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              lock_set,
  input logic              cfg_we,
  input logic              cfg_violation,
  input logic              wr_valid,
  input logic              wr_resp_valid,
  input logic              wr_allow,
  input logic              map_valid,
  input logic              map_resp_valid,
  input logic              map_allow,
  input logic              fault,
  input logic              flt_valid,
  input logic              flt_clear,
  input logic [ADDR_W-1:0] flt_addr
);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);

  // R7
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n) lock_set |=> locked);

  // R8
  cfg_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_violation |-> $past(cfg_we && locked));

  // R1
  prelock_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_valid) |=> wr_allow);

  // R9
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> wr_resp_valid);

  // R9
  map_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) map_valid |=> map_resp_valid);

  // R9
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ((wr_resp_valid && !wr_allow) || (map_resp_valid && !map_allow)));

  // R10
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clear) |=> (flt_valid && $stable(flt_addr)));

endmodule

bind prot_region_guard prot_region_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .lock_set(lock_set), .cfg_we(cfg_we),
  .cfg_violation(cfg_violation), .wr_valid(wr_valid), .wr_resp_valid(wr_resp_valid),
  .wr_allow(wr_allow), .map_valid(map_valid), .map_resp_valid(map_resp_valid),
  .map_allow(map_allow), .fault(fault), .flt_valid(flt_valid), .flt_clear(flt_clear),
  .flt_addr(flt_addr)
);

// File: tb/prot_region_guard_test.sv
module prot_region_guard_test;
  localparam int AW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic cfg_sel_limit = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic lock_set = 1'b0;
  logic locked, cfg_violation;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [IW-1:0] wr_id = '0;
  logic wr_resp_valid, wr_allow;
  logic map_valid = 1'b0;
  logic map_ready;
  logic [AW-1:0] map_addr = '0;
  logic [IW-1:0] map_id = '0;
  logic map_w = 1'b0, map_x = 1'b0, map_p = 1'b0;
  logic map_resp_valid, map_allow;
  logic fault;
  logic flt_clear = 1'b0;
  logic flt_valid, flt_src;
  logic [AW-1:0] flt_addr;
  logic [IW-1:0] flt_id;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  prot_region_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel_limit(cfg_sel_limit), .cfg_wdata(cfg_wdata), .lock_set(lock_set),
    .locked(locked), .cfg_violation(cfg_violation), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_id(wr_id),
    .wr_resp_valid(wr_resp_valid), .wr_allow(wr_allow), .map_valid(map_valid),
    .map_ready(map_ready), .map_addr(map_addr), .map_id(map_id), .map_w(map_w),
    .map_x(map_x), .map_p(map_p), .map_resp_valid(map_resp_valid),
    .map_allow(map_allow), .fault(fault), .flt_clear(flt_clear),
    .flt_valid(flt_valid), .flt_src(flt_src), .flt_addr(flt_addr), .flt_id(flt_id)
  );

  // kind, id, w, x, p, addr, expected allow
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'b000, 32'h0000_1000, 1'b0},  // R2 base of kernel region
    {1'b0, 2'd0, 3'b000, 32'h0000_1FFF, 1'b0},  // R6 last inside
    {1'b0, 2'd0, 3'b000, 32'h0000_2000, 1'b1},  // R6 limit excluded
    {1'b0, 2'd0, 3'b000, 32'h0000_0FFF, 1'b1},  // R6 below base
    {1'b0, 2'd1, 3'b000, 32'h0000_3200, 1'b0},  // R2 coprocessor region
    {1'b0, 2'd2, 3'b000, 32'h0000_7800, 1'b1},  // R6 empty region
    {1'b1, 2'd0, 3'b010, 32'h0000_1800, 1'b1},  // R3 exec inside own
    {1'b1, 2'd0, 3'b010, 32'h0000_2000, 1'b0},  // R3 exec at limit
    {1'b1, 2'd0, 3'b001, 32'h0000_0800, 1'b0},  // R3 privileged outside
    {1'b1, 2'd0, 3'b100, 32'h0000_1800, 1'b0},  // R4 writable inside own
    {1'b1, 2'd0, 3'b100, 32'h0000_2800, 1'b1},  // R4 writable outside
    {1'b1, 2'd0, 3'b000, 32'h0000_1800, 1'b1},  // R4 no flags
    {1'b1, 2'd1, 3'b010, 32'h0000_1800, 1'b0},  // R5 coproc exec in kernel
    {1'b1, 2'd1, 3'b010, 32'h0000_3000, 1'b1},  // R5 coproc exec in own
    {1'b1, 2'd1, 3'b100, 32'h0000_3000, 1'b0},  // R5 coproc writable own
    {1'b1, 2'd1, 3'b100, 32'h0000_1800, 1'b1},  // R5 kernel region not own
    {1'b1, 2'd2, 3'b010, 32'h0000_7800, 1'b0},  // R6 empty own region
    {1'b1, 2'd3, 3'b010, 32'h0000_1800, 1'b0},  // R5 id owning nothing
    {1'b1, 2'd3, 3'b100, 32'h0000_1800, 1'b1}   // R5 id owning nothing
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic lim, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel_limit = lim; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_write(input logic [IW-1:0] id, input logic [AW-1:0] a);
    wr_valid = 1'b1; wr_id = id; wr_addr = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_map(input logic [IW-1:0] id, input logic [2:0] f, input logic [AW-1:0] a);
    map_valid = 1'b1; map_id = id; {map_w, map_x, map_p} = f; map_addr = a;
    @(negedge clk);
    map_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset locked", 64'(locked), 0);
    check("R10 reset flt_valid", 64'(flt_valid), 0);
    check("R9 reset fault", 64'(fault), 0);
    check("R9 ready", 64'({wr_ready, map_ready}), 64'h3);

    cfg_write(0, 1'b0, 32'h1000); cfg_write(0, 1'b1, 32'h2000);
    cfg_write(1, 1'b0, 32'h3000); cfg_write(1, 1'b1, 32'h3400);
    cfg_write(2, 1'b0, 32'h8000); cfg_write(2, 1'b1, 32'h7000);

    do_write(2'd0, 32'h1800);
    check("R1 prelock write", 64'({wr_resp_valid, wr_allow, fault}), 64'h6);
    do_map(2'd1, 3'b110, 32'h1800);
    check("R1 prelock map", 64'({map_resp_valid, map_allow, fault}), 64'h6);
    check("R10 no capture prelock", 64'(flt_valid), 0);

    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    check("R7 lock set", 64'(locked), 1);
    repeat (3) @(negedge clk);
    check("R7 lock sticky", 64'(locked), 1);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      if (v[38]) begin
        do_map(v[37:36], v[35:33], v[32:1]);
        check($sformatf("R3/R4/R5 map vec %0d", i), 64'({map_resp_valid, map_allow}), 64'({1'b1, v[0]}));
      end else begin
        do_write(v[37:36], v[32:1]);
        check($sformatf("R2/R6 write vec %0d", i), 64'({wr_resp_valid, wr_allow}), 64'({1'b1, v[0]}));
      end
      check($sformatf("R9 fault vec %0d", i), 64'(fault), 64'(!v[0]));
    end

    @(negedge clk);
    check("R9 fault one cycle", 64'({fault, wr_resp_valid, map_resp_valid}), 0);
    check("R10 first fault held", 64'({flt_valid, flt_src, flt_id, flt_addr}),
          64'({1'b1, 1'b0, 2'd0, 32'h1000}));

    flt_clear = 1'b1;
    @(negedge clk);
    flt_clear = 1'b0;
    check("R10 clear", 64'(flt_valid), 0);

    wr_valid = 1'b1; wr_id = 2'd1; wr_addr = 32'h3100;
    map_valid = 1'b1; map_id = 2'd3; {map_w, map_x, map_p} = 3'b010; map_addr = 32'h1800;
    @(negedge clk);
    wr_valid = 1'b0; map_valid = 1'b0;
    check("R10 both denied, write captured", 64'({flt_valid, flt_src, flt_id, flt_addr}),
          64'({1'b1, 1'b0, 2'd1, 32'h3100}));

    cfg_write(0, 1'b1, 32'h1000);
    check("R8 violation pulse", 64'(cfg_violation), 1);
    @(negedge clk);
    check("R8 violation one cycle", 64'(cfg_violation), 0);
    do_write(2'd0, 32'h1800);
    check("R8 region still active", 64'({wr_resp_valid, wr_allow}), 64'h2);
    cfg_write(2, 1'b1, 32'hF000);
    do_write(2'd0, 32'h8800);
    check("R8 empty region unchanged", 64'({wr_resp_valid, wr_allow}), 64'h3);
    check("R10 capture kept", 64'(flt_addr), 64'h3100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule